// File: doc/BRIEF.md
# Paged Nonvolatile Byte Array Controller

This block sits between a CPU's register port and a small byte-organised nonvolatile array, which is modelled here as a register file of 32 pages of four bytes. Software points a 7-bit address register at a byte and loads up to four page latches through a data register. It then starts a program cycle by writing the control register. The controller times each program cycle with an internal counter, raises busy for the whole cycle and moves the address pointer on afterwards. Multi-byte loads, multi-page programming and streamed reads therefore need no address arithmetic in software.

Two program cycles exist. A plain write ORs the latches into the addressed page, so it can only set bits. An erase/write first clears every byte whose latch was loaded, during one timed phase. It then reloads the timer and ORs the latches in during a second phase of the same length. Reading the data register returns the array byte under the pointer and advances the pointer, crossing page boundaries freely.

Top module: `eeprom_page_ctrl`

## Requirements
- R1: After reset, `ptr` is 0 and `busy`, `erase_phase` and `rvalid` are all 0.
- R2: A register write with `reg_sel` = 0 loads `ptr` with `wdata[6:0]`. Bits [1:0] of the pointer pick the byte lane and bits [6:2] pick one of 32 pages.
- R3: A register write with `reg_sel` = 1 stores `wdata` in the latch of lane `ptr[1:0]` and marks that latch as loaded. If increment mode is on (control bit 0 set by the last control write), `ptr[1:0]` then steps by one modulo 4 and the page bits are kept. Otherwise `ptr` is unchanged.
- R4: A control write (`reg_sel` = 2) with bit 1 set and bit 2 clear starts a write-page cycle. `busy` stays high for exactly `PROG_CYCLES` clock cycles and `erase_phase` stays low. Each byte of the addressed page becomes its old value ORed with its latch.
- R5: A control write with bits 1 and 2 both set starts an erase/write cycle. `erase_phase` is high for the first `PROG_CYCLES` cycles. `busy` then stays high for a further `PROG_CYCLES` cycles. Each loaded byte ends equal to its latch value and the other bytes of the page are unchanged.
- R6: When a write-page or erase/write cycle ends, `ptr` increments by one modulo 128. From lane 3 it therefore reaches lane 0 of the next page, and from 127 it reaches 0.
- R7: A register read with `reg_sel` = 1 gives `rvalid` high one cycle later, with `rdata` holding the array byte at the pre-read `ptr`. `ptr` then increments by one modulo 128, ignoring page boundaries.
- R8: While `busy` is high, register writes and reads are ignored: `ptr`, the mode and the latches keep their values, no `rvalid` appears and no new cycle starts.
- R9: When a cycle ends, every latch returns to 0 and all loaded marks clear, so a later cycle leaves bytes that were not reloaded unchanged.
- R10: Array bytes that have never been programmed read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_sel | input | 2 | Register select: 0 address, 1 data, 2 control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid with `rvalid` |
| rvalid | output | 1 | Read data valid |
| busy | output | 1 | Program cycle in progress |
| erase_phase | output | 1 | Erase phase of an erase/write cycle |
| ptr | output | 7 | Current address pointer |

## Verification
The bench builds the block with `PROG_CYCLES` = 6. A full erase/write cycle then takes twelve clocks, so phase lengths can be counted exactly, and register accesses issued mid-cycle land inside the busy window. The default address width is kept, which puts the wrap from 127 to 0 and the crossings from lane 3 to the next page within a short run. Read-back through the scoreboard confirms the OR merge, the single-lane erase/write and the zero contents of untouched bytes.

// File: rtl/eepc_pkg.sv
package eepc_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_ERASE, PH_PROG} phase_t;
  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;
  localparam int CTRL_INC   = 0;
  localparam int CTRL_GO    = 1;
  localparam int CTRL_ERASE = 2;
endpackage

// File: rtl/eepc_latches.sv
module eepc_latches #(
  parameter int LANES  = 4,
  parameter int DATA_W = 8,
  localparam int LW    = $clog2(LANES)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic [LW-1:0]           lane,
  input  logic [DATA_W-1:0]       din,
  input  logic                    clear,
  output logic [LANES*DATA_W-1:0] lat_word,
  output logic [LANES-1:0]        loaded
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst || clear) begin
        lat_word[g*DATA_W +: DATA_W] <= '0;
        loaded[g]                    <= 1'b0;
      end else if (load && lane == LW'(g)) begin
        lat_word[g*DATA_W +: DATA_W] <= din;
        loaded[g]                    <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/eepc_timer.sv
module eepc_timer #(
  parameter int PROG_CYCLES = 500000,
  localparam int CW = $clog2(PROG_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  logic [CW-1:0] cnt;

  assign done = run && (cnt == CW'(PROG_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst || !run || done) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/eepc_array.sv
module eepc_array #(
  parameter int PAGES  = 32,
  parameter int WORD_W = 32,
  localparam int PW    = $clog2(PAGES)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PW-1:0]     page,
  input  logic [WORD_W-1:0] wword,
  output logic [WORD_W-1:0] rword
);
  logic [WORD_W-1:0] mem [PAGES];

  initial begin
    for (int i = 0; i < PAGES; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[page] <= wword;
    rword <= mem[page];
  end
endmodule

// File: rtl/eeprom_page_ctrl.sv
module eeprom_page_ctrl #(
  parameter int ADDR_W      = 7,
  parameter int LANE_W      = 2,
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              busy,
  output logic              erase_phase,
  output logic [ADDR_W-1:0] ptr
);
  import eepc_pkg::*;

  localparam int LANES  = 1 << LANE_W;
  localparam int PAGES  = 1 << (ADDR_W - LANE_W);
  localparam int WORD_W = LANES * DATA_W;

  phase_t              phase;
  logic                inc_mode;
  logic                idle, acc_we, acc_re, start, done, finish;
  logic [LANE_W-1:0]   lane_q;
  logic [WORD_W-1:0]   lat_word, rd_word, wr_word, erase_mask;
  logic [LANES-1:0]    loaded;

  assign idle        = (phase == PH_IDLE);
  assign busy        = !idle;
  assign erase_phase = (phase == PH_ERASE);
  assign acc_we      = reg_we && idle;
  assign acc_re      = reg_re && idle && reg_sel == SEL_DATA;
  assign start       = acc_we && reg_sel == SEL_CTRL && wdata[CTRL_GO];
  assign finish      = (phase == PH_PROG) && done;

  eepc_latches #(.LANES(LANES), .DATA_W(DATA_W)) u_lat (
    .clk(clk), .rst(rst),
    .load(acc_we && reg_sel == SEL_DATA),
    .lane(ptr[LANE_W-1:0]), .din(wdata),
    .clear(finish), .lat_word(lat_word), .loaded(loaded)
  );

  eepc_timer #(.PROG_CYCLES(PROG_CYCLES)) u_tmr (
    .clk(clk), .rst(rst), .run(busy), .done(done)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_mask
    assign erase_mask[g*DATA_W +: DATA_W] = {DATA_W{loaded[g]}};
  end

  assign wr_word = erase_phase ? (rd_word & ~erase_mask) : (rd_word | lat_word);

  eepc_array #(.PAGES(PAGES), .WORD_W(WORD_W)) u_arr (
    .clk(clk), .we(done), .page(ptr[ADDR_W-1:LANE_W]),
    .wword(wr_word), .rword(rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      inc_mode <= 1'b0;
      ptr      <= '0;
      rvalid   <= 1'b0;
      lane_q   <= '0;
    end else begin
      rvalid <= acc_re;
      if (acc_re) begin
        lane_q <= ptr[LANE_W-1:0];
        ptr    <= ptr + 1'b1;
      end
      if (acc_we) begin
        case (reg_sel)
          SEL_ADDR: ptr <= wdata[ADDR_W-1:0];
          SEL_DATA: if (inc_mode)
                      ptr[LANE_W-1:0] <= ptr[LANE_W-1:0] + 1'b1;
          SEL_CTRL: inc_mode <= wdata[CTRL_INC];
          default: ;
        endcase
      end
      case (phase)
        PH_IDLE:  if (start) phase <= wdata[CTRL_ERASE] ? PH_ERASE : PH_PROG;
        PH_ERASE: if (done) phase <= PH_PROG;
        PH_PROG:  if (done) begin
                    phase <= PH_IDLE;
                    ptr   <= ptr + 1'b1;
                  end
        default:  phase <= PH_IDLE;
      endcase
    end
  end

  assign rdata = rd_word[lane_q*DATA_W +: DATA_W];
endmodule

// File: rtl/eepc_checker.sv
module eepc_checker #(
  parameter int ADDR_W      = 7,
  parameter int PROG_CYCLES = 500000,
  localparam int CW = $clog2(2 * PROG_CYCLES + 2) + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_re,
  input logic [1:0]        reg_sel,
  input logic              rvalid,
  input logic              busy,
  input logic              erase_phase,
  input logic [ADDR_W-1:0] ptr
);
  logic [CW-1:0] busy_run;

  always_ff @(posedge clk) begin
    if (rst || !busy) busy_run <= '0;
    else              busy_run <= busy_run + 1'b1;
  end

  a_r8_ptr_frozen: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!busy || $stable(ptr)));

  a_r5_erase_in_busy: assert property (@(posedge clk) disable iff (rst)
    erase_phase |-> busy);

  a_r5_reload_keeps_busy: assert property (@(posedge clk) disable iff (rst)
    $fell(erase_phase) |-> busy);

  a_r6_ptr_step: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ptr == ADDR_W'($past(ptr) + 1'b1));

  a_r7_rvalid_cause: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> $past(reg_re && reg_sel == 2'd1 && !busy));

  a_r4_busy_bound: assert property (@(posedge clk) disable iff (rst)
    busy_run <= CW'(2 * PROG_CYCLES));
endmodule

bind eeprom_page_ctrl eepc_checker #(.ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .reg_re(reg_re), .reg_sel(reg_sel), .rvalid(rvalid),
  .busy(busy), .erase_phase(erase_phase), .ptr(ptr)
);

// File: tb/eeprom_page_ctrl_bench.sv
module eeprom_page_ctrl_bench;
  localparam int P = 6;

  logic clk = 0, rst = 1, reg_we = 0, reg_re = 0;
  logic [1:0] reg_sel = 0;
  logic [7:0] wdata = 0, rdata;
  logic rvalid, busy, erase_phase;
  logic [6:0] ptr;

  int n_chk = 0, n_bad = 0;
  int busy_cyc = 0, erase_cyc = 0;
  logic [7:0] model [128];
  logic [7:0] exp_q [$];
  string      tag_q [$];

  eeprom_page_ctrl #(.PROG_CYCLES(P)) u_eeprom_page_ctrl (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_sel(reg_sel),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .busy(busy),
    .erase_phase(erase_phase), .ptr(ptr)
  );

  always #5 clk = ~clk;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (busy) busy_cyc++;
    if (erase_phase) erase_cyc++;
    if (rvalid) begin
      if (exp_q.size() == 0) check("R8 unexpected rvalid", 1, 0);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic wr(logic [1:0] sel, logic [7:0] v);
    @(negedge clk); reg_we = 1; reg_sel = sel; wdata = v;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(string req, bit expect_data);
    @(negedge clk);
    if (expect_data) begin exp_q.push_back(model[ptr]); tag_q.push_back(req); end
    reg_re = 1; reg_sel = 2'd1;
    @(negedge clk); reg_re = 0;
  endtask

  task automatic go(logic [7:0] ctl);
    busy_cyc = 0; erase_cyc = 0;
    wr(2'd2, ctl);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    check("watchdog", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 ptr", ptr, 0);
    check("R1 busy", busy, 0);
    check("R1 erase_phase", erase_phase, 0);
    check("R1 rvalid", rvalid, 0);

    // increment-mode page fill, then OR write
    wr(2'd2, 8'h01);
    wr(2'd0, 8'd8);
    check("R2 ptr load", ptr, 8);
    wr(2'd1, 8'h81); wr(2'd1, 8'h42); wr(2'd1, 8'h24); wr(2'd1, 8'h18);
    check("R3 lane wrap in page", ptr, 8);
    go(8'h03);
    wait_idle();
    check("R4 busy length", busy_cyc, P);
    check("R4 no erase phase", erase_cyc, 0);
    check("R6 ptr after write", ptr, 9);
    model[8] = 8'h81; model[9] = 8'h42; model[10] = 8'h24; model[11] = 8'h18;
    wr(2'd0, 8'd8);
    for (int i = 0; i < 4; i++) rd("R4 page readback", 1);
    check("R7 ptr after reads", ptr, 12);

    // single lane OR without increment
    wr(2'd2, 8'h00);
    wr(2'd0, 8'd9);
    wr(2'd1, 8'h0F);
    check("R3 no increment", ptr, 9);
    go(8'h02);
    wait_idle();
    check("R4 busy length 2", busy_cyc, P);
    model[9] = model[9] | 8'h0F;
    wr(2'd0, 8'd8);
    for (int i = 0; i < 4; i++) rd("R9 only lane 1 merged", 1);

    // erase/write single byte
    wr(2'd0, 8'd10);
    wr(2'd1, 8'h55);
    go(8'h06);
    wait_idle();
    check("R5 busy length", busy_cyc, 2 * P);
    check("R5 erase length", erase_cyc, P);
    check("R6 ptr after erase/write", ptr, 11);
    model[10] = 8'h55;

    // accesses during busy are ignored; lane 3 steps to next page
    wr(2'd0, 8'd15);
    wr(2'd1, 8'hC3);
    go(8'h06);
    wr(2'd0, 8'h40);
    wr(2'd2, 8'h06);
    rd("R8 read while busy", 0);
    wait_idle();
    check("R8 no restart", busy_cyc, 2 * P);
    check("R6 R8 ptr next page", ptr, 16);
    repeat (2) @(negedge clk);
    check("R8 idle after", busy, 0);
    model[15] = 8'hC3;

    // last byte, pointer wraps
    wr(2'd0, 8'd127);
    wr(2'd1, 8'h7E);
    go(8'h06);
    wait_idle();
    check("R6 ptr wrap", ptr, 0);
    model[127] = 8'h7E;

    wr(2'd0, 8'd8);
    for (int i = 0; i < 4; i++) rd("R5 page after erase/write", 1);
    wr(2'd0, 8'd15);
    rd("R5 lane 3 byte", 1);
    rd("R10 blank byte", 1);
    wr(2'd0, 8'd126);
    for (int i = 0; i < 3; i++) rd("R7 stream across wrap", 1);
    check("R7 ptr wrap", ptr, 1);
    repeat (3) @(negedge clk);
    check("R7 queue drained", exp_q.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule